// File: doc/BRIEF.md
# Speculative Gshare Direction Predictor with History Recovery

This block predicts whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters. Each table entry is chosen by XORing word-address bits of the branch PC with a global history register. The history register takes in each predicted direction as soon as the prediction is made. This lets back-to-back predictions see the directions of the older branches still in flight, without waiting for them to resolve.

Each accepted prediction saves the history it was made with in a checkpoint slot and returns that slot number as a tag. A resolved branch returns its tag, its table index and its real direction. The counter is trained at that point. If the branch was mispredicted, the saved history is reloaded and the true outcome is shifted in, and every younger branch is discarded. While all checkpoint slots are in use, the block raises a stall and accepts no new prediction.

Top module: `gshare_ckpt_pred`

## Requirements
- R1: After reset every counter holds 1 (weakly not-taken), the history is zero, no slot is in use, and `stall` and `pred_out_valid` are low.
- R2: An accepted request gives `pred_out_valid` high on the next cycle, with `pred_taken` equal to bit 1 of the selected counter (values 2 and 3 mean taken).
- R3: The table index is `pred_pc[IDX_W+1:2]` XOR the history register. PC bits 1:0 are never used.
- R4: Each accepted prediction shifts its predicted direction into history bit 0, and older bits move one place up.
- R5: A resolve trains the counter at `res_idx`: taken adds 1 up to 3, not-taken subtracts 1 down to 0.
- R6: Tags are handed out as 0, 1, 2, … modulo `CKPT_N` from reset. Every resolve names the oldest branch in flight, and a correct resolve frees that slot.
- R7: `stall` is high exactly when `CKPT_N` branches are in flight. A request made while `stall` is high produces no output and leaves the history unchanged.
- R8: A mispredict resolve sets the history to the resolved branch's checkpoint shifted up by one with `res_taken` in bit 0. It frees every slot, and the next tag handed out is the mispredicted tag plus one.
- R9: A request in the same cycle as a mispredict resolve is dropped.
- R10: A prediction in the same cycle as a counter update reads the counter value from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_valid | input | 1 | Prediction request |
| pred_pc | input | PC_W | Branch PC |
| stall | output | 1 | No free checkpoint slot |
| pred_out_valid | output | 1 | Prediction result valid |
| pred_taken | output | 1 | Predicted direction |
| pred_tag | output | TAG_W | Checkpoint slot of the branch |
| pred_idx | output | IDX_W | Table index used |
| res_valid | input | 1 | Resolve strobe |
| res_tag | input | TAG_W | Slot of the resolved branch |
| res_idx | input | IDX_W | Index recorded at prediction |
| res_taken | input | 1 | Actual direction |
| res_mispred | input | 1 | Prediction was wrong |

## Verification
The bench first repeats a single branch with taken outcomes. This drives the counters through weak and strong states and shows whether saturation and the history-dependent index both move the prediction. Next, a burst of requests with no resolves fills every slot and then presses against the stall. After that, a mispredict arrives with younger branches in flight and a competing request in the same cycle, which separates correct recovery from simply carrying on. A long random mix of requests, in-order resolves and mispredicts then compares every output against a behavioural model on every clock, which exposes ordering faults such as reading a counter after its update.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
  localparam logic [1:0] CTR_INIT = 2'd1;

  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    else    return (c == 2'd0) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/gsp_table.sv
module gsp_table #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken
);
  import gsp_pkg::*;
  localparam int DEPTH = 1 << IDX_W;

  logic [1:0] mem [DEPTH];

  // asynchronous read port: the old value is seen during a same-cycle write (R10)
  assign rd_ctr = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
    end else if (upd_en) begin
      mem[upd_idx] <= ctr_step(mem[upd_idx], upd_taken);
    end
  end

  a_r5_sat_high: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_taken && mem[upd_idx] == 2'd3) |=> (mem[$past(upd_idx)] == 2'd3));
  a_r5_sat_low: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !upd_taken && mem[upd_idx] == 2'd0) |=> (mem[$past(upd_idx)] == 2'd0));
endmodule

// File: rtl/gsp_ckpt_fifo.sv
module gsp_ckpt_fifo #(
  parameter int DEPTH = 4,
  parameter int HW    = 8,
  localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [HW-1:0] push_hist,
  input  logic          pop,
  input  logic          flush,
  output logic [TW-1:0] tail,
  output logic [TW-1:0] head,
  output logic [HW-1:0] head_hist,
  output logic          full,
  output logic          empty
);
  // DEPTH must be a power of two so the pointers wrap naturally
  logic [HW-1:0] ck_mem [DEPTH];
  logic [TW:0]   count;

  assign head_hist = ck_mem[head];
  assign full      = (count == (TW+1)'(DEPTH));
  assign empty     = (count == '0);

  always_ff @(posedge clk) begin
    if (push) ck_mem[tail] <= push_hist;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (flush) begin
      head  <= head + 1'b1;
      tail  <= head + 1'b1;
      count <= '0;
    end else begin
      head  <= head + TW'(pop);
      tail  <= tail + TW'(push);
      count <= count + (TW+1)'(push) - (TW+1)'(pop);
    end
  end

  a_r8_flush_frees_all: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
  a_r7_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
    full |-> !push);
  a_r6_pop_needs_entry: assert property (@(posedge clk) disable iff (rst)
    (pop || flush) |-> !empty);
endmodule

// File: rtl/gshare_ckpt_pred.sv
module gshare_ckpt_pred #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 8,
  parameter int CKPT_N = 4,
  localparam int TAG_W = (CKPT_N > 1) ? $clog2(CKPT_N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pred_valid,
  input  logic [PC_W-1:0]  pred_pc,
  output logic             stall,
  output logic             pred_out_valid,
  output logic             pred_taken,
  output logic [TAG_W-1:0] pred_tag,
  output logic [IDX_W-1:0] pred_idx,
  input  logic             res_valid,
  input  logic [TAG_W-1:0] res_tag,
  input  logic [IDX_W-1:0] res_idx,
  input  logic             res_taken,
  input  logic             res_mispred
);
  logic [IDX_W-1:0] hist_q;
  logic [IDX_W-1:0] idx_now;
  logic [1:0]       ctr_now;
  logic             taken_now;
  logic             recover;
  logic             accept;
  logic             retire;
  logic [TAG_W-1:0] alloc_tag;
  logic [TAG_W-1:0] oldest_tag;
  logic [IDX_W-1:0] saved_hist;
  logic             slots_full;
  logic             slots_empty;

  // R3: skip the two byte-offset bits of a 4-byte instruction
  assign idx_now   = pred_pc[IDX_W+1:2] ^ hist_q;
  assign taken_now = ctr_now[1];
  assign recover   = res_valid && res_mispred;
  assign accept    = pred_valid && !slots_full && !recover;   // R7, R9
  assign retire    = res_valid && !res_mispred;
  assign stall     = slots_full;

  gsp_table #(.IDX_W(IDX_W)) u_table (
    .clk(clk), .rst(rst),
    .rd_idx(idx_now), .rd_ctr(ctr_now),
    .upd_en(res_valid), .upd_idx(res_idx), .upd_taken(res_taken)
  );

  gsp_ckpt_fifo #(.DEPTH(CKPT_N), .HW(IDX_W)) u_ckpt (
    .clk(clk), .rst(rst),
    .push(accept), .push_hist(hist_q),
    .pop(retire), .flush(recover),
    .tail(alloc_tag), .head(oldest_tag), .head_hist(saved_hist),
    .full(slots_full), .empty(slots_empty)
  );

  // R4 speculative shift, R8 restore plus correction
  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (recover) begin
      hist_q <= {saved_hist[IDX_W-2:0], res_taken};
    end else if (accept) begin
      hist_q <= {hist_q[IDX_W-2:0], taken_now};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_out_valid <= 1'b0;
      pred_taken     <= 1'b0;
      pred_tag       <= '0;
      pred_idx       <= '0;
    end else begin
      pred_out_valid <= accept;
      if (accept) begin
        pred_taken <= taken_now;
        pred_tag   <= alloc_tag;
        pred_idx   <= idx_now;
      end
    end
  end

  a_r6_resolve_oldest: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_tag == oldest_tag && !slots_empty));
  a_r7_stall_blocks: assert property (@(posedge clk) disable iff (rst)
    (stall && pred_valid) |=> !pred_out_valid);
  a_r9_recover_drops: assert property (@(posedge clk) disable iff (rst)
    recover |=> !pred_out_valid);
  a_r4_hist_takes_pred: assert property (@(posedge clk) disable iff (rst)
    accept |=> (hist_q[0] == pred_taken));
  a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (rst)
    pred_out_valid |-> $past(pred_valid));
endmodule

// File: tb/gshare_ckpt_pred_test.sv
module gshare_ckpt_pred_test;
  localparam int PC_W = 32;
  localparam int IDX_W = 8;
  localparam int N = 4;
  localparam int TAG_W = 2;
  localparam int DEPTH = 1 << IDX_W;
  localparam int MASK = DEPTH - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pred_valid = 1'b0;
  logic [PC_W-1:0] pred_pc = '0;
  logic stall, pred_out_valid, pred_taken;
  logic [TAG_W-1:0] pred_tag;
  logic [IDX_W-1:0] pred_idx;
  logic res_valid = 1'b0;
  logic [TAG_W-1:0] res_tag = '0;
  logic [IDX_W-1:0] res_idx = '0;
  logic res_taken = 1'b0;
  logic res_mispred = 1'b0;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  gshare_ckpt_pred #(.PC_W(PC_W), .IDX_W(IDX_W), .CKPT_N(N)) uut (
    .clk(clk), .rst(rst),
    .pred_valid(pred_valid), .pred_pc(pred_pc),
    .stall(stall), .pred_out_valid(pred_out_valid), .pred_taken(pred_taken),
    .pred_tag(pred_tag), .pred_idx(pred_idx),
    .res_valid(res_valid), .res_tag(res_tag), .res_idx(res_idx),
    .res_taken(res_taken), .res_mispred(res_mispred)
  );

  // behavioural reference model
  int ctr [DEPTH];
  int mh, ntag;
  int qh[$], qi[$], qt[$];
  int exp_ov, exp_taken, exp_tag, exp_idx, exp_stall;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ctr[i] = 1;
      mh = 0; ntag = 0;
      qh.delete(); qi.delete(); qt.delete();
      exp_ov = 0; exp_stall = 0;
    end else begin
      int mis, acc, idx, t;
      mis = (res_valid && res_mispred) ? 1 : 0;
      acc = (pred_valid && exp_stall == 0 && mis == 0) ? 1 : 0;
      exp_ov = acc;
      if (acc != 0) begin
        idx = (int'(pred_pc >> 2) ^ mh) & MASK;
        t = (ctr[idx] >= 2) ? 1 : 0;          // read before update: R10
        exp_taken = t; exp_tag = ntag; exp_idx = idx;
        qh.push_back(mh); qi.push_back(idx); qt.push_back(ntag);
        ntag = (ntag + 1) % N;
        mh = ((mh << 1) | t) & MASK;
      end
      if (res_valid) begin
        if (res_taken) ctr[res_idx] = (ctr[res_idx] == 3) ? 3 : ctr[res_idx] + 1;
        else           ctr[res_idx] = (ctr[res_idx] == 0) ? 0 : ctr[res_idx] - 1;
        if (mis != 0) begin
          mh = ((qh[0] << 1) | int'(res_taken)) & MASK;
          ntag = (int'(res_tag) + 1) % N;
          qh.delete(); qi.delete(); qt.delete();
        end else begin
          void'(qh.pop_front()); void'(qi.pop_front()); void'(qt.pop_front());
        end
      end
      exp_stall = (qh.size() == N) ? 1 : 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 R9 pred_out_valid", int'(pred_out_valid), exp_ov);
      chk("R7 stall", int'(stall), exp_stall);
      if (exp_ov != 0) begin
        chk("R2 R5 R10 pred_taken", int'(pred_taken), exp_taken);
        chk("R6 R8 pred_tag", int'(pred_tag), exp_tag);
        chk("R3 R4 pred_idx", int'(pred_idx), exp_idx);
      end
    end
  end

  task automatic cyc(input bit pv, input int pc, input bit rv, input bit rt, input bit rm);
    @(negedge clk);
    #1;
    pred_valid = pv;
    pred_pc = PC_W'(pc);
    if (rv && qt.size() > 0) begin
      res_valid = 1'b1;
      res_tag = TAG_W'(qt[0]);
      res_idx = IDX_W'(qi[0]);
      res_taken = rt;
      res_mispred = rm;
    end else begin
      res_valid = 1'b0;
      res_mispred = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1..R10 run did not complete actual=hang expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1: idle state after reset
    chk("R1 stall after reset", int'(stall), 0);
    chk("R1 out_valid after reset", int'(pred_out_valid), 0);
    // R1: first prediction sees counter 1 -> not taken, tag 0
    cyc(1, 32'h100, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R1 first prediction not taken", int'(pred_taken), 0);
    chk("R6 first tag", int'(pred_tag), 0);
    cyc(0, 0, 1, 1, 0);
    // R5: train one branch repeatedly taken
    for (int k = 0; k < 10; k++) begin
      cyc(1, 32'h104, 0, 0, 0);
      cyc(0, 0, 1, 1, 0);
    end
    // R7: fill every slot, then push against stall
    for (int k = 0; k < N + 2; k++) cyc(1, 32'h200 + 4 * k, 0, 0, 0);
    // R8 R9: mispredict oldest with younger in flight and a competing request
    cyc(1, 32'h300, 1, 1, 1);
    cyc(1, 32'h304, 0, 0, 0);
    cyc(1, 32'h308, 1, 0, 1);
    cyc(0, 0, 0, 0, 0);
    // random mix
    for (int k = 0; k < 4000; k++) begin
      cyc(($urandom % 3) != 0, int'($urandom % 4096) & ~3 | int'($urandom % 4),
          ($urandom % 2) == 0, ($urandom % 2) == 0, ($urandom % 5) == 0);
    end
    cyc(0, 0, 0, 0, 0);
    @(negedge clk);
    finish_run();
  end
endmodule